// File: doc/BRIEF.md
# GPIO Level Interrupt Cause Unit

This block turns the levels on a set of general-purpose input pins into a single interrupt request. Each pin has a polarity bit that selects whether a high or a low level counts as active. When an enabled pin sits at its active level, its bit in a sticky cause register sets and stays set until software writes a 1 to the matching bit of a clear register. The combined request output rises when any cause bit that is both enabled and unmasked is set.

The pins are brought into the clock domain through a two-stage synchroniser. The enable, mask, cause and clear registers are wider than the pin count, and each pin's bit sits at a fixed field offset plus the pin number. A small write/read bus with a word address reaches the registers. Because causes are level-driven, a pin that is still active when its bit is cleared latches again on the next cycle. Software therefore flips the polarity first and then clears, so that no stale event is seen.

Top module: `gpio_irq_cause`

## Requirements
- R1: The polarity register (address 0, bit i for pin i) selects the active level: 0 means a high pin level is active, 1 means a low level is active.
- R2: Pin i is at bit FIELD_OFS+i (default FIELD_OFS=2) in the enable register (address 1), the mask register (address 2), the cause register (address 3, read-only) and the clear register (address 4, write-only, reads 0). Reads of any other address return 0.
- R3: A cause bit is sticky. It stays set until a 1 is written to its clear bit. Writing 0 to a clear bit has no effect.
- R4: If a pin is still active and enabled in the cycle its bit is cleared, the set wins and the bit remains set. Changing the polarity first and clearing in a later cycle leaves the bit clear.
- R5: The reserved pin (default 8) and every pin above the highest input-capable pin (default 13) never set a cause bit, whatever their level and configuration.
- R6: Polarity writes keep only the NUM_PINS implemented bits, and bits at or above NUM_PINS read as 0.
- R7: The irq output is the OR over all pins of cause AND enable AND mask, registered by one cycle. A masked cause still reads as set in the cause register.
- R8: Clearing a pin's enable bit stops new events from being latched, but it leaves an already set cause bit in place.
- R9: Pin levels pass through two synchronising registers. An active level applied before clock edge k sets the cause bit at edge k+2, and irq follows one edge later.
- R10: After reset all registers read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busAddr | input | 3 | Word address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| pinIn | input | 16 | Asynchronous pin levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench clears a bit while its pin is still active and expects the bit to remain set. A design that let the clear win would lose a real event that is still pending. It also flips the polarity before clearing and expects the bit to stay clear; a design that sampled the old polarity would raise a spurious event. It drives the reserved pin and the pins above the input range high with every enable set, so a design that ignored the valid-pin rule would latch causes there. It drops an enable with a cause pending, writes zeros to the clear register, and masks a pending cause, which catches a design that clears on disable, treats the clear write as a plain store, or lets masked causes reach irq.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_POL   = 3'd0,
    ADDR_ENA   = 3'd1,
    ADDR_MSK   = 3'd2,
    ADDR_CAUSE = 3'd3,
    ADDR_CLR   = 3'd4
  } regAddr_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_POL,
    RD_ENA,
    RD_MSK,
    RD_CAUSE
  } rdSel_e;

  typedef struct packed {
    logic   wrPol;
    logic   wrEna;
    logic   wrMsk;
    logic   wrClr;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gic_ctrl.sv
module gic_ctrl
  import gic_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe = '{wrPol: 1'b0, wrEna: 1'b0, wrMsk: 1'b0, wrClr: 1'b0, rdSel: RD_NONE};
    case (busAddr)
      ADDR_POL: begin
        strobe.wrPol = busWrEn;
        strobe.rdSel = RD_POL;
      end
      ADDR_ENA: begin
        strobe.wrEna = busWrEn;
        strobe.rdSel = RD_ENA;
      end
      ADDR_MSK: begin
        strobe.wrMsk = busWrEn;
        strobe.rdSel = RD_MSK;
      end
      ADDR_CAUSE: strobe.rdSel = RD_CAUSE;
      ADDR_CLR:   strobe.wrClr = busWrEn;
      default:    strobe.rdSel = RD_NONE;
    endcase
  end

  // R2: at most one register is written per cycle
  always_comb begin
    a_r2_one_write: assert ($countones({strobe.wrPol, strobe.wrEna, strobe.wrMsk, strobe.wrClr}) <= 1)
      else $error("R2: more than one write strobe");
  end
endmodule

// File: rtl/gic_datapath.sv
module gic_datapath
  import gic_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int NUM_PINS    = 16,
  parameter int FIELD_OFS   = 2,
  parameter int RSVD_PIN    = 8,
  parameter int MAX_IN_PIN  = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [REG_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [REG_W-1:0]    rdData,
  output logic                irq
);
  logic [NUM_PINS-1:0] polReg, enaReg, mskReg, causeReg;
  logic [NUM_PINS-1:0] pinSync, validPin, activeVec, setVec, clrVec;
  logic [NUM_PINS-1:0] wrField;

  assign wrField = wrData[FIELD_OFS +: NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_valid
    assign validPin[i] = (i != RSVD_PIN) && (i <= MAX_IN_PIN);
  end

  gic_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinIn),
    .syncOut(pinSync)
  );

  // polarity 0: high active, 1: low active
  assign activeVec = pinSync ^ polReg;
  assign setVec    = activeVec & enaReg & validPin;
  assign clrVec    = strobe.wrClr ? wrField : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polReg <= '0;
      enaReg <= '0;
      mskReg <= '0;
    end else begin
      if (strobe.wrPol) polReg <= wrData[NUM_PINS-1:0];
      if (strobe.wrEna) enaReg <= wrField;
      if (strobe.wrMsk) mskReg <= wrField;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) causeReg <= '0;
    else       causeReg <= setVec | (causeReg & ~clrVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(causeReg & enaReg & mskReg);
  end

  always_comb begin
    case (strobe.rdSel)
      RD_POL:   rdData = REG_W'(polReg);
      RD_ENA:   rdData = REG_W'(enaReg) << FIELD_OFS;
      RD_MSK:   rdData = REG_W'(mskReg) << FIELD_OFS;
      RD_CAUSE: rdData = REG_W'(causeReg) << FIELD_OFS;
      default:  rdData = '0;
    endcase
  end

  // R3: a set bit not cleared stays set
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeReg & $past(causeReg & ~clrVec)) == $past(causeReg & ~clrVec)))
    else $error("R3: cause bit dropped without clear");

  // R4: an active enabled pin ends up set even if cleared in that cycle
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeReg & $past(setVec)) == $past(setVec)))
    else $error("R4: set condition lost");

  // R5: invalid pins never latch
  a_r5_invalid_pin: assert property (@(posedge clk) disable iff (!rstN)
    (causeReg & ~validPin) == '0)
    else $error("R5: cause on reserved or output-only pin");

  // R8: a new cause needs the enable bit in the previous cycle
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeReg & ~$past(causeReg) & ~$past(enaReg)) == '0))
    else $error("R8: cause latched while disabled");

  // R7: irq only follows a pending cause
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|causeReg))
    else $error("R7: irq without cause");
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gic_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int NUM_PINS   = 16,
  parameter int FIELD_OFS  = 2,
  parameter int RSVD_PIN   = 8,
  parameter int MAX_IN_PIN = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [REG_W-1:0]    busWrData,
  output logic [REG_W-1:0]    busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irq
);
  ctrlStrobe_t strobe;

  gic_ctrl u_ctrl (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gic_datapath #(
    .REG_W     (REG_W),
    .NUM_PINS  (NUM_PINS),
    .FIELD_OFS (FIELD_OFS),
    .RSVD_PIN  (RSVD_PIN),
    .MAX_IN_PIN(MAX_IN_PIN)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(busWrData),
    .pinIn (pinIn),
    .rdData(busRdData),
    .irq   (irq)
  );
endmodule

// File: tb/gpio_irq_cause_tb_top.sv
module gpio_irq_cause_tb_top;
  localparam int NP  = 16;
  localparam int OFS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NP-1:0] pinIn = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  gpio_irq_cause dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .irq(irq)
  );

  always #2 clk = ~clk;

  // reference model
  logic [NP-1:0] mPol, mEna, mMsk, mCause, mS1, mS2;
  logic mIrq;

  function automatic logic [NP-1:0] validMask();
    logic [NP-1:0] v = '0;
    for (int i = 0; i < NP; i++) v[i] = (i != 8) && (i <= 13);
    return v;
  endfunction

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return 32'(mPol);
      3'd1: return 32'(mEna) << OFS;
      3'd2: return 32'(mMsk) << OFS;
      3'd3: return 32'(mCause) << OFS;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [NP-1:0] setV, clrV, fld;
    if (!rstN) begin
      mPol = '0; mEna = '0; mMsk = '0; mCause = '0; mS1 = '0; mS2 = '0; mIrq = 1'b0;
    end else begin
      fld  = busWrData[OFS +: NP];
      setV = (mS2 ^ mPol) & mEna & validMask();
      clrV = (busWrEn && busAddr == 3'd4) ? fld : '0;
      mIrq = |(mCause & mEna & mMsk);
      mCause = setV | (mCause & ~clrV);
      mS2 = mS1;
      mS1 = pinIn;
      if (busWrEn && busAddr == 3'd0) mPol = busWrData[NP-1:0];
      if (busWrEn && busAddr == 3'd1) mEna = fld;
      if (busWrEn && busAddr == 3'd2) mMsk = fld;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    busAddr = a;
    #0.5;
    check(req, busRdData, exp);
    check({req, " model"}, busRdData, modelRead(a));
  endtask

  function automatic logic [31:0] f(input logic [NP-1:0] v);
    return 32'(v) << OFS;
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 5; a++) rdChk("R10 reset read", 3'(a), 32'd0);
    check("R10 irq reset", 32'(irq), 32'd0);

    // R6 polarity write masking
    wr(3'd0, 32'hFFFF_FFFF);
    rdChk("R6 polarity mask", 3'd0, 32'h0000_FFFF);
    wr(3'd0, 32'd0);

    // R1/R9: pin 3 high active, timing
    wr(3'd1, f(16'h0008));
    wr(3'd2, f(16'h0008));
    @(negedge clk); pinIn = 16'h0008;     // before edge k
    @(negedge clk);                        // after edge k
    rdChk("R9 not yet set after one edge", 3'd3, 32'd0);
    @(negedge clk);                        // after k+1
    rdChk("R9 not yet set after two edges", 3'd3, 32'd0);
    @(negedge clk);                        // after k+2
    rdChk("R9 cause set after k+2", 3'd3, f(16'h0008));
    check("R9 irq lags cause", 32'(irq), 32'd0);
    @(negedge clk);
    check("R7 irq raised", 32'(irq), 32'd1);

    // R3 writing zero to clear leaves the bit
    pinIn = 16'h0000;
    repeat (3) cyc();
    wr(3'd4, 32'd0);
    rdChk("R3 zero clear ignored", 3'd3, f(16'h0008));
    wr(3'd4, f(16'h0008));
    rdChk("R3 clear by one", 3'd3, 32'd0);
    @(negedge clk);
    check("R7 irq drops", 32'(irq), 32'd0);

    // R1 low-active pin 4
    wr(3'd1, f(16'h0010));
    wr(3'd0, 32'h0000_0010);
    repeat (3) cyc();
    rdChk("R1 low level active", 3'd3, f(16'h0010));
    // R4 clear while still active: set wins
    wr(3'd4, f(16'h0010));
    rdChk("R4 reassert after clear", 3'd3, f(16'h0010));
    // R4 polarity flip then clear
    wr(3'd0, 32'd0);
    wr(3'd4, f(16'h0010));
    rdChk("R4 polarity then clear stays clear", 3'd3, 32'd0);

    // R7 masked cause visible, irq low
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0000_0010);
    repeat (3) cyc();
    rdChk("R7 masked cause visible", 3'd3, f(16'h0010));
    check("R7 masked irq low", 32'(irq), 32'd0);

    // R8 disable keeps pending cause, stops new
    wr(3'd1, 32'd0);
    rdChk("R8 cause kept after disable", 3'd3, f(16'h0010));
    wr(3'd0, 32'd0);
    wr(3'd4, f(16'h0010));
    wr(3'd0, 32'h0000_0010);
    repeat (4) cyc();
    rdChk("R8 no new cause while disabled", 3'd3, 32'd0);

    // R5 invalid pins
    wr(3'd0, 32'd0);
    pinIn = 16'hC100;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    repeat (4) cyc();
    rdChk("R5 reserved and high pins ignored", 3'd3, 32'd0);
    check("R5 irq low", 32'(irq), 32'd0);
    // R2 field position and unmapped reads
    rdChk("R2 enable field", 3'd1, f(16'hFFFF));
    rdChk("R2 clear reads zero", 3'd4, 32'd0);
    rdChk("R2 unmapped reads zero", 3'd6, 32'd0);

    // random phase against model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      pinIn = 16'($urandom);
      busWrEn = ($urandom % 3) == 0;
      busAddr = 3'($urandom % 6);
      busWrData = $urandom;
      #0.5;
      check("R2 random read", busRdData, modelRead(busAddr));
      check("R7 random irq", 32'(irq), 32'(mIrq));
    end
    busWrEn = 1'b0;
    @(negedge clk);
    rdChk("R3 random final cause", 3'd3, modelRead(3'd3));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule